// File: doc/BRIEF.md
# Banked Scratchpad Wavefront Splitter

This block takes one warp-wide request to a 32-bank scratchpad (32 lanes, each with an enable bit and a byte address, and one access width shared by all lanes). It cuts the request into wavefronts whose lane count depends on the width. Inside each wavefront it works out which banks are touched and which word each bank serves first. It also works out how many extra replay cycles the wavefront needs because two or more distinct words fall on the same bank.

A request is taken through a valid/ready handshake. From the next cycle on, the block presents one non-empty wavefront per cycle, in ascending group order, and flags the final one. With every wavefront it also gives running totals for the request: wavefronts issued including replays, and excess wavefronts, meaning the replays alone. The required split into several wavefronts for wide accesses never counts as excess. The block holds no storage array and models only the scheduling of one request.

Top module: `scratch_wf_splitter`

## Requirements
- R1: The width code on `req_size` selects the grouping. Code 0 means 4 bytes: one wavefront, lanes 0-31. Code 1 means 8 bytes: two wavefronts, lanes 0-15 then 16-31. Code 2 means 16 bytes: four wavefronts of 8 consecutive lanes each. `wf_index` gives the group number, so no wavefront moves more than 128 bytes.
- R2: A lane's first word is its byte address shifted right by 2. An 8-byte lane covers that word and the next one, and a 16-byte lane covers four consecutive words. The bank of a word is its value modulo 32, so banks wrap from 31 to 0.
- R3: Lanes in one wavefront that touch the same word share one access and never conflict. Patterns where lane n matches lane n^1, or lane n matches lane n^2, therefore cost no replays.
- R4: `wf_replays` equals the largest number of distinct words that map to one bank within the wavefront, minus one.
- R5: Inactive lanes take no part in any check and do not appear in `wf_lanes`. A group with no active lane produces no output and is not counted.
- R6: A request with no active lane is accepted and produces no wavefront at all.
- R7: Wavefronts appear on consecutive cycles, starting the cycle after acceptance, in ascending group order. `wf_last` is set only on the final one.
- R8: `req_ready` is low during every cycle in which a wavefront is presented, and high when none is pending.
- R9: Bit b of `wf_bank_hit` is set exactly when some active lane of the wavefront touches bank b. Field b of `wf_bank_word` (bits b*14 upward) holds the word from the lowest lane touching b; among the words of that lane, the lowest one is taken.
- R10: With each wavefront, `req_wavefronts` gives the number of non-empty wavefronts so far plus all replays so far, and `req_excess` gives all replays so far. Both values include the current wavefront.
- R11: After reset, `req_ready` is high and `wf_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_size | input | 2 | Width code: 0=4 B, 1=8 B, 2=16 B |
| req_active | input | 32 | Per-lane enable |
| req_addr | input | 32*ADDR_W | Lane byte addresses, lane i at bits i*ADDR_W |
| wf_valid | output | 1 | Wavefront presented |
| wf_last | output | 1 | Final wavefront of the request |
| wf_index | output | 2 | Group number of the wavefront |
| wf_lanes | output | 32 | Active lanes in this wavefront |
| wf_bank_hit | output | 32 | Banks touched |
| wf_bank_word | output | 32*(ADDR_W-2) | First word served by each bank |
| wf_replays | output | 6 | Extra replay cycles for this wavefront |
| req_wavefronts | output | 8 | Running wavefront total including replays |
| req_excess | output | 8 | Running replay total |

## Verification
Broadcast merging and replay counting act in the same cycle and on the same bank. A bank can hold repeated copies of one word together with a second, distinct word. In that case the repeats must be merged, and only the second word may raise the replay count. The bench builds such wavefronts on purpose: all lanes on one word, uniform pair patterns, lanes on a 128-byte stride, and random addresses packed into a narrow window. An independent model in the bench keeps a list of distinct words for each bank. Each presented wavefront is compared against that model for replays, bank map and running totals.

// File: rtl/scratch_wf_pkg.sv
package scratch_wf_pkg;

    localparam int NUM_LANES = 32;
    localparam int NUM_BANKS = 32;
    localparam int BANK_BITS = $clog2(NUM_BANKS);
    localparam int LANE_BITS = $clog2(NUM_LANES);
    localparam int MAX_GROUPS = 4;
    localparam int CNT_W = $clog2(NUM_BANKS) + 1;
    localparam int TOT_W = 8;

    typedef enum logic [1:0] {
        ACC_W4  = 2'd0,
        ACC_W8  = 2'd1,
        ACC_W16 = 2'd2
    } acc_size_e;

    // log2 of 4-byte words per lane
    function automatic int size_log(acc_size_e sz);
        case (sz)
            ACC_W8:  return 1;
            ACC_W16: return 2;
            default: return 0;
        endcase
    endfunction

    function automatic int group_count(acc_size_e sz);
        return 1 << size_log(sz);
    endfunction

    // lanes belonging to group g for width sz
    function automatic logic [NUM_LANES-1:0] group_mask(acc_size_e sz, int g);
        logic [NUM_LANES-1:0] m;
        int sh;
        sh = LANE_BITS - size_log(sz);
        m = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if ((i >> sh) == g) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/wf_sequencer.sv
module wf_sequencer
    import scratch_wf_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            req_valid,
    output logic                            req_ready,
    input  acc_size_e                       req_size,
    input  logic [NUM_LANES-1:0]            req_active,
    input  logic [NUM_LANES*ADDR_W-1:0]     req_addr,
    input  logic [CNT_W-1:0]                replays,
    output logic                            wf_valid,
    output logic                            wf_last,
    output logic [1:0]                      wf_sel,
    output acc_size_e                       size_q,
    output logic [NUM_LANES-1:0]            act_q,
    output logic [NUM_LANES*ADDR_W-1:0]     addr_q,
    output logic [TOT_W-1:0]                tot_out,
    output logic [TOT_W-1:0]                exc_out
);

    logic                 busy_q;
    logic [1:0]           cur_q;
    logic [TOT_W-1:0]     tot_q, exc_q;
    logic [MAX_GROUPS-1:0] nonempty;
    logic                 found, more;

    always_comb begin
        for (int g = 0; g < MAX_GROUPS; g++) begin
            nonempty[g] = (g < group_count(size_q)) &&
                          (|(act_q & group_mask(size_q, g)));
        end
        found  = 1'b0;
        wf_sel = '0;
        for (int g = 0; g < MAX_GROUPS; g++) begin
            if (!found && nonempty[g] && (g >= int'(cur_q))) begin
                found  = 1'b1;
                wf_sel = 2'(g);
            end
        end
        more = 1'b0;
        for (int g = 0; g < MAX_GROUPS; g++) begin
            if (nonempty[g] && (g > int'(wf_sel))) more = 1'b1;
        end
    end

    assign req_ready = !busy_q;
    assign wf_valid  = busy_q && found;
    assign wf_last   = wf_valid && !more;
    assign tot_out   = tot_q + TOT_W'(1) + TOT_W'(replays);
    assign exc_out   = exc_q + TOT_W'(replays);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cur_q  <= '0;
            tot_q  <= '0;
            exc_q  <= '0;
            size_q <= ACC_W4;
            act_q  <= '0;
            addr_q <= '0;
        end else if (req_valid && req_ready) begin
            busy_q <= |req_active;
            cur_q  <= '0;
            tot_q  <= '0;
            exc_q  <= '0;
            size_q <= req_size;
            act_q  <= req_active;
            addr_q <= req_addr;
        end else if (wf_valid) begin
            if (wf_last) busy_q <= 1'b0;
            cur_q <= wf_sel + 2'd1;
            tot_q <= tot_out;
            exc_q <= exc_out;
        end
    end

    assert_single_group_w4_R1: assert property (@(posedge clk) disable iff (rst)
        (wf_valid && size_q == ACC_W4) |-> (wf_sel == 2'd0));

    assert_no_ready_while_emit_R8: assert property (@(posedge clk) disable iff (rst)
        wf_valid |-> !req_ready);

    assert_quiet_after_last_R7: assert property (@(posedge clk) disable iff (rst)
        (wf_valid && wf_last) |=> !wf_valid);

    assert_ascending_groups_R7: assert property (@(posedge clk) disable iff (rst)
        (wf_valid && !wf_last) |=> (wf_valid && wf_sel > $past(wf_sel)));

endmodule

// File: rtl/wf_slot_gather.sv
module wf_slot_gather
    import scratch_wf_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int WORD_W = ADDR_W - 2
) (
    input  acc_size_e                       size,
    input  logic [NUM_LANES-1:0]            active,
    input  logic [NUM_LANES*ADDR_W-1:0]     addr,
    input  logic [1:0]                      sel,
    output logic [NUM_LANES-1:0]            lanes,
    output logic [NUM_BANKS-1:0]            slot_vld,
    output logic [NUM_BANKS*WORD_W-1:0]     slot_word
);

    // Every wavefront spans exactly 32 word slots: lanes x words per lane.
    always_comb begin
        int s;
        int lane;
        int woff;
        s = size_log(size);
        lanes = active & group_mask(size, int'(sel));
        for (int k = 0; k < NUM_BANKS; k++) begin
            lane = (int'(sel) << (LANE_BITS - s)) | (k >> s);
            woff = k & ((1 << s) - 1);
            slot_vld[k] = active[lane];
            slot_word[k*WORD_W +: WORD_W] =
                addr[lane*ADDR_W + 2 +: WORD_W] + WORD_W'(woff);
        end
    end

endmodule

// File: rtl/wf_bank_resolver.sv
module wf_bank_resolver
    import scratch_wf_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int WORD_W = ADDR_W - 2
) (
    input  logic [NUM_BANKS-1:0]            slot_vld,
    input  logic [NUM_BANKS*WORD_W-1:0]     slot_word,
    output logic [NUM_BANKS-1:0]            bank_hit,
    output logic [NUM_BANKS*WORD_W-1:0]     bank_word,
    output logic [CNT_W-1:0]                replays
);

    logic [WORD_W-1:0]    w      [NUM_BANKS];
    logic [NUM_BANKS-1:0] first;
    logic [CNT_W-1:0]     cnt    [NUM_BANKS];
    logic [CNT_W-1:0]     peak;

    always_comb begin
        for (int k = 0; k < NUM_BANKS; k++) begin
            w[k] = slot_word[k*WORD_W +: WORD_W];
        end
        // a slot counts only if no earlier valid slot holds the same word
        for (int k = 0; k < NUM_BANKS; k++) begin
            first[k] = slot_vld[k];
            for (int j = 0; j < k; j++) begin
                if (slot_vld[j] && w[j] == w[k]) first[k] = 1'b0;
            end
        end
        peak = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            cnt[b]      = '0;
            bank_hit[b] = 1'b0;
            bank_word[b*WORD_W +: WORD_W] = '0;
            for (int k = NUM_BANKS - 1; k >= 0; k--) begin
                if (first[k] && w[k][BANK_BITS-1:0] == BANK_BITS'(b)) begin
                    cnt[b]      = cnt[b] + CNT_W'(1);
                    bank_hit[b] = 1'b1;
                    bank_word[b*WORD_W +: WORD_W] = w[k];
                end
            end
            if (cnt[b] > peak) peak = cnt[b];
        end
        replays = (peak == '0) ? '0 : peak - CNT_W'(1);
    end

endmodule

// File: rtl/scratch_wf_splitter.sv
module scratch_wf_splitter
    import scratch_wf_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int WORD_W = ADDR_W - 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [1:0]                  req_size,
    input  logic [31:0]                 req_active,
    input  logic [32*ADDR_W-1:0]        req_addr,
    output logic                        wf_valid,
    output logic                        wf_last,
    output logic [1:0]                  wf_index,
    output logic [31:0]                 wf_lanes,
    output logic [31:0]                 wf_bank_hit,
    output logic [32*WORD_W-1:0]        wf_bank_word,
    output logic [5:0]                  wf_replays,
    output logic [7:0]                  req_wavefronts,
    output logic [7:0]                  req_excess
);

    acc_size_e                   size_q;
    logic [NUM_LANES-1:0]        act_q;
    logic [NUM_LANES*ADDR_W-1:0] addr_q;
    logic [NUM_BANKS-1:0]        slot_vld;
    logic [NUM_BANKS*WORD_W-1:0] slot_word;
    logic [CNT_W-1:0]            replays;

    wf_sequencer #(.ADDR_W(ADDR_W)) i_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_size   (acc_size_e'(req_size)),
        .req_active (req_active),
        .req_addr   (req_addr),
        .replays    (replays),
        .wf_valid   (wf_valid),
        .wf_last    (wf_last),
        .wf_sel     (wf_index),
        .size_q     (size_q),
        .act_q      (act_q),
        .addr_q     (addr_q),
        .tot_out    (req_wavefronts),
        .exc_out    (req_excess)
    );

    wf_slot_gather #(.ADDR_W(ADDR_W)) i_gather (
        .size      (size_q),
        .active    (act_q),
        .addr      (addr_q),
        .sel       (wf_index),
        .lanes     (wf_lanes),
        .slot_vld  (slot_vld),
        .slot_word (slot_word)
    );

    wf_bank_resolver #(.ADDR_W(ADDR_W)) i_resolve (
        .slot_vld  (slot_vld),
        .slot_word (slot_word),
        .bank_hit  (wf_bank_hit),
        .bank_word (wf_bank_word),
        .replays   (replays)
    );

    assign wf_replays = replays;

    assert_lone_slot_no_replay_R4: assert property (@(posedge clk) disable iff (rst)
        (wf_valid && $countones(slot_vld) <= 1) |-> (wf_replays == '0));

    assert_lanes_nonempty_R5: assert property (@(posedge clk) disable iff (rst)
        wf_valid |-> (wf_lanes != '0 && wf_bank_hit != '0));

    assert_excess_below_total_R10: assert property (@(posedge clk) disable iff (rst)
        wf_valid |-> (req_excess < req_wavefronts));

    assert_replays_fit_banks_R9: assert property (@(posedge clk) disable iff (rst)
        wf_valid |-> (int'(wf_replays) < $countones(slot_vld)
                      || wf_replays == '0));

endmodule

// File: tb/test_scratch_wf_splitter.sv
module test_scratch_wf_splitter;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int WORD_W = ADDR_W - 2;

    typedef struct {
        logic [1:0]          idx;
        logic [31:0]         lanes;
        logic [31:0]         hit;
        logic [32*WORD_W-1:0] words;
        logic [5:0]          rep;
        logic                last;
        logic [7:0]          tot;
        logic [7:0]          exc;
    } wf_item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_size = 2'd0;
    logic [31:0] req_active = '0;
    logic [32*ADDR_W-1:0] req_addr = '0;
    logic wf_valid, wf_last;
    logic [1:0] wf_index;
    logic [31:0] wf_lanes, wf_bank_hit;
    logic [32*WORD_W-1:0] wf_bank_word;
    logic [5:0] wf_replays;
    logic [7:0] req_wavefronts, req_excess;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    wf_item_t expq[$];
    logic [ADDR_W-1:0] a [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    scratch_wf_splitter #(.ADDR_W(ADDR_W)) i_scratch_wf_splitter (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_size(req_size), .req_active(req_active), .req_addr(req_addr),
        .wf_valid(wf_valid), .wf_last(wf_last), .wf_index(wf_index),
        .wf_lanes(wf_lanes), .wf_bank_hit(wf_bank_hit),
        .wf_bank_word(wf_bank_word), .wf_replays(wf_replays),
        .req_wavefronts(req_wavefronts), .req_excess(req_excess)
    );

    task automatic check(bit ok, string tag, logic [447:0] act, logic [447:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Independent model: per-bank lists of distinct words (R2 R3 R4 R9 R10)
    task automatic send(logic [1:0] sz, logic [31:0] act);
        int s, lpw, wpl, nwf, pushed;
        logic [7:0] tot, exc;
        s = (sz == 2'd1) ? 1 : (sz == 2'd2) ? 2 : 0;
        lpw = 32 >> s; wpl = 1 << s; nwf = 1 << s;
        tot = 0; exc = 0; pushed = 0;
        for (int g = 0; g < nwf; g++) begin
            wf_item_t it;
            logic [WORD_W-1:0] lst [32][32];
            int n [32];
            int peak;
            it.lanes = '0; it.hit = '0; it.words = '0;
            for (int b = 0; b < 32; b++) n[b] = 0;
            for (int l = g*lpw; l < (g+1)*lpw; l++) begin
                if (!act[l]) continue;
                it.lanes[l] = 1'b1;
                for (int o = 0; o < wpl; o++) begin
                    logic [WORD_W-1:0] w;
                    int b;
                    bit seen;
                    w = a[l][ADDR_W-1:2] + WORD_W'(o);
                    b = int'(w[4:0]);
                    seen = 1'b0;
                    for (int e = 0; e < n[b]; e++) if (lst[b][e] == w) seen = 1'b1;
                    if (!seen) begin
                        if (n[b] == 0) begin
                            it.hit[b] = 1'b1;
                            it.words[b*WORD_W +: WORD_W] = w;
                        end
                        lst[b][n[b]] = w;
                        n[b]++;
                    end
                end
            end
            if (it.lanes == '0) continue;
            peak = 0;
            for (int b = 0; b < 32; b++) if (n[b] > peak) peak = n[b];
            it.rep = 6'(peak - 1);
            it.idx = 2'(g);
            tot = tot + 8'd1 + 8'(it.rep);
            exc = exc + 8'(it.rep);
            it.tot = tot; it.exc = exc; it.last = 1'b0;
            expq.push_back(it);
            pushed++;
        end
        if (pushed > 0) expq[expq.size()-1].last = 1'b1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_size = sz; req_active = act;
        for (int l = 0; l < 32; l++) req_addr[l*ADDR_W +: ADDR_W] = a[l];
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while ((expq.size() != 0 || !req_ready) && guard < 200) begin
            @(negedge clk); guard++;
        end
    endtask

    // Monitor: compares each presented wavefront with the queue head
    always @(negedge clk) begin
        if (!rst && wf_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R6/R5 unexpected wavefront", 448'(wf_lanes), 448'(0));
            end else begin
                wf_item_t e;
                e = expq.pop_front();
                check(wf_index == e.idx && wf_lanes == e.lanes,
                      "R1/R5 group and lanes", {wf_index, wf_lanes}, {e.idx, e.lanes});
                check(wf_last == e.last, "R7 last flag", 448'(wf_last), 448'(e.last));
                check(wf_replays == e.rep, "R4 replays", 448'(wf_replays), 448'(e.rep));
                check(wf_bank_hit == e.hit && wf_bank_word == e.words,
                      "R9 bank map", {wf_bank_hit, wf_bank_word}, {e.hit, e.words});
                check(req_wavefronts == e.tot && req_excess == e.exc,
                      "R10 totals", {req_wavefronts, req_excess}, {e.tot, e.exc});
                check(!req_ready, "R8 ready low while emitting", 448'(req_ready), 448'(0));
            end
        end
    end

    initial begin
        #(CLK_PERIOD*100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(req_ready == 1'b1 && wf_valid == 1'b0, "R11 reset state",
              {req_ready, wf_valid}, 448'(2));

        // R2 4-byte stride 4: all banks distinct
        for (int l = 0; l < 32; l++) a[l] = ADDR_W'(4*l);
        send(2'd0, '1); drain();
        // R4 4-byte stride 8: two words per even bank
        for (int l = 0; l < 32; l++) a[l] = ADDR_W'(8*l);
        send(2'd0, '1); drain();
        // R1 8-byte consecutive: two wavefronts, no excess
        send(2'd1, '1); drain();
        // R1 16-byte consecutive: four wavefronts
        for (int l = 0; l < 32; l++) a[l] = ADDR_W'(16*l);
        send(2'd2, '1); drain();
        // R4 stride 128 bytes: all on bank 0, 31 replays
        for (int l = 0; l < 32; l++) a[l] = ADDR_W'(128*l);
        send(2'd0, '1); drain();
        // R3 broadcast of one word
        for (int l = 0; l < 32; l++) a[l] = 16'h0040;
        send(2'd0, '1); drain();
        // R3 uniform pairs n^1 with 8-byte width
        for (int l = 0; l < 32; l++) a[l] = ADDR_W'(8*(l >> 1));
        send(2'd1, '1); drain();
        // R3 uniform pairs n^2 with 4-byte width
        for (int l = 0; l < 32; l++) a[l] = ADDR_W'(4*(((l >> 2) << 1) | (l & 1)));
        send(2'd0, '1); drain();
        // R5 first group empty, only group 1 emitted
        for (int l = 0; l < 32; l++) a[l] = ADDR_W'(8*l);
        send(2'd1, 32'hFFFF_0000); drain();
        // R5 16-byte with only group 2 active, sparse lanes
        for (int l = 0; l < 32; l++) a[l] = ADDR_W'(16*l);
        send(2'd2, 32'h0050_0000); drain();
        // R2 16-byte wrap from bank 31 to bank 0, plus a conflict
        for (int l = 0; l < 32; l++) a[l] = 16'h0000;
        a[0] = 16'd124; a[1] = 16'd256;
        send(2'd2, 32'h0000_0003); drain();
        // R6 all lanes inactive: no output, ready stays high
        send(2'd1, '0);
        repeat (3) begin
            @(negedge clk);
            check(!wf_valid && req_ready, "R6 empty request silent",
                  {wf_valid, req_ready}, 448'(1));
        end
        // R7 back-to-back requests without draining
        for (int l = 0; l < 32; l++) a[l] = ADDR_W'(4*l + 64*(l & 3));
        send(2'd2, '1);
        send(2'd1, 32'hF0F0_0F0F);
        drain();
        // random mixes in a narrow window to force merges and conflicts
        for (int r = 0; r < 40; r++) begin
            logic [1:0] sz;
            sz = 2'($urandom_range(0, 2));
            for (int l = 0; l < 32; l++) a[l] = ADDR_W'(($urandom_range(0, 95)) << (2 + int'(sz)));
            send(sz, (r % 5 == 0) ? '1 : $urandom);
        end
        drain();
        check(expq.size() == 0, "R7 all wavefronts seen", 448'(expq.size()), 448'(0));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        done = 1'b1;
        $finish;
    end

endmodule